// File: doc/BRIEF.md
# Flash Buffered-Write Staging Unit

This unit carries out the multi-word buffered programming sequence of a parallel flash array. After a start command, the next write supplies a word count and an address. That address selects a window of the array that is aligned to the buffer size. The unit then copies the array's current contents for that window into a private staging buffer, one bus word per clock. The data writes that follow change only the staging buffer.

A final confirm byte decides the outcome. If the byte is the commit code and no program error is pending, the whole buffer is copied back into the array, again one word per clock. In every other case the buffer is thrown away and the array is left as it was. The unit also drives the ready and program-error bits that the flash status register reports. Only one window can be open at a time.

All writes on the command/data port are whole bus words. Commands and the confirm code are taken from data bits [7:0].

Top module: `flash_bufwrite_stager`

## Requirements
- R1: After reset the unit has no open window and is not busy. Ready reads 1, program error reads 0 and the read-array pulse is 0.
- R2: In idle, a write with data[7:0] = 0xE8 starts a sequence and clears the program-error bit. The next write fixes the window base as that write's address with its low log2(buffer bytes) bits cleared. The same write fixes the count as its data masked to the device width in bytes, or to the bank width if the device width is 0. The buffer holds 256 bytes when the bank is 1 byte wide and 2048 bytes otherwise, multiplied by (bank width / device width) when that ratio exceeds 1. With the defaults this is 4096 bytes.
- R3: When the window opens, every array word of the window is copied into the buffer. A commit therefore leaves untouched words of the window at their earlier values.
- R4: A data write whose start address is below the window base, or whose last byte lies at or beyond base plus buffer size, changes nothing and sets the program-error bit. That bit stays set until the next start command.
- R5: A sequence with count N accepts exactly N+1 data writes, and the write after those is the confirm write. Each data write sets the ready bit.
- R6: A confirm write with data[7:0] = 0xD0 and no pending program error copies the buffer into the array. The window then closes, the unit returns to idle and ready is set.
- R7: Any other confirm byte, or a pending program error, discards the buffer. In that case the array is unchanged, the window closes and the read-array output pulses high for one cycle.
- R8: With the read-only input high, data writes do not change the buffer and set the program-error bit.
- R9: The copy into the buffer and the copy out of it each hold busy high for exactly buffer-words + 1 cycles. Ready reads 0 while a copy runs.
- R10: In idle, writes whose data[7:0] is not 0xE8 have no effect: no window opens and the array is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ro_i | input | 1 | Device is read-only |
| wr_valid_i | input | 1 | Command/data write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 8*BUS_BYTES | Write data |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_rd_o | output | 1 | Array read request; data returns one cycle later |
| arr_rdata_i | input | 8*BUS_BYTES | Array read data |
| arr_we_o | output | 1 | Array write enable |
| arr_wdata_o | output | 8*BUS_BYTES | Array write data |
| busy_o | output | 1 | A copy-in or copy-out is running |
| ready_o | output | 1 | Status ready bit |
| prog_err_o | output | 1 | Status program-error bit |
| win_valid_o | output | 1 | A staging window is open |
| read_array_o | output | 1 | One-cycle pulse on an aborted sequence |

## Verification
The count is sent with nonzero upper bits. A unit that failed to mask it would keep taking writes as data, so the confirm would never be seen and the array would stay stale. The bench sends exactly N+1 writes before the confirm, which exposes an off-by-one that would treat the last data word as a bad confirm and abort. Writes are aimed at the last word of a window, one word below the base and one word past the end. These catch a window check that is too loose or too tight. A commit after an error, and a read-only sequence, show whether a unit lets a flagged buffer reach the array. Busy lengths are counted cycle by cycle on both copies.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    localparam logic [7:0] CMD_START   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FILL,
        ST_DATA,
        ST_CONFIRM,
        ST_DRAIN
    } stage_e;

    // staging size in bytes for a bank of bus_b bytes built from dev_b-byte parts
    function automatic int fbw_buf_bytes(int bus_b, int dev_b);
        int ndev;
        int base_sz;
        ndev    = (dev_b == 0) ? 1 : bus_b / dev_b;
        base_sz = (bus_b == 1) ? 256 : 2048;
        return (ndev > 1) ? base_sz * ndev : base_sz;
    endfunction

endpackage

// File: rtl/fbw_window.sv
module fbw_window #(
    parameter int ADDR_W    = 13,
    parameter int BUS_BYTES = 4,
    parameter int BUF_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] base_of_o,
    output logic              in_win_o,
    output logic [$clog2(BUF_BYTES/BUS_BYTES)-1:0] widx_o
);
    localparam int WB     = $clog2(BUS_BYTES);
    localparam int BUF_AW = $clog2(BUF_BYTES);

    logic [ADDR_W:0] wr_end;
    logic [ADDR_W:0] win_end;

    always_comb begin
        base_of_o = addr_i & ~ADDR_W'(BUF_BYTES - 1);
        wr_end    = {1'b0, addr_i} + (ADDR_W+1)'(BUS_BYTES);
        win_end   = {1'b0, base_i} + (ADDR_W+1)'(BUF_BYTES);
        in_win_o  = (addr_i >= base_i) && (wr_end <= win_end);
        widx_o    = addr_i[BUF_AW-1:WB];
    end

endmodule

// File: rtl/fbw_stage_buf.sv
module fbw_stage_buf #(
    parameter int WORDS = 1024,
    parameter int WIDTH = 32
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [$clog2(WORDS)-1:0] waddr_i,
    input  logic [WIDTH-1:0]         wdata_i,
    input  logic [$clog2(WORDS)-1:0] raddr_i,
    output logic [WIDTH-1:0]         rdata_o
);
    logic [WIDTH-1:0] mem_q [WORDS];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/flash_bufwrite_stager.sv
module flash_bufwrite_stager
    import fbw_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BUS_BYTES = 4,
    parameter int DEV_BYTES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   ro_i,
    input  logic                   wr_valid_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [8*BUS_BYTES-1:0] wr_data_i,
    output logic [ADDR_W-1:0]      arr_addr_o,
    output logic                   arr_rd_o,
    input  logic [8*BUS_BYTES-1:0] arr_rdata_i,
    output logic                   arr_we_o,
    output logic [8*BUS_BYTES-1:0] arr_wdata_o,
    output logic                   busy_o,
    output logic                   ready_o,
    output logic                   prog_err_o,
    output logic                   win_valid_o,
    output logic                   read_array_o
);
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int CNT_BYTES = (DEV_BYTES == 0) ? BUS_BYTES : DEV_BYTES;
    localparam int CNT_W     = 8 * CNT_BYTES;
    localparam int BUF_BYTES = fbw_buf_bytes(BUS_BYTES, DEV_BYTES);
    localparam int BUF_WORDS = BUF_BYTES / BUS_BYTES;
    localparam int WB        = $clog2(BUS_BYTES);
    localparam int IW        = $clog2(BUF_WORDS);
    localparam int IDX_W     = IW + 1;

    typedef struct packed {
        stage_e            state;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [IW-1:0]     pidx;
        logic              pend;
        logic              win;
        logic              rdy;
        logic              err;
        logic              ra;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] base_of;
    logic              in_win;
    logic [IW-1:0]     wr_widx;
    logic              buf_we;
    logic [IW-1:0]     buf_widx;
    logic [BUS_W-1:0]  buf_wdata;
    logic [BUS_W-1:0]  buf_rdata;
    logic              idx_end;

    fbw_window #(
        .ADDR_W   (ADDR_W),
        .BUS_BYTES(BUS_BYTES),
        .BUF_BYTES(BUF_BYTES)
    ) win_i (
        .addr_i   (wr_addr_i),
        .base_i   (q.base),
        .base_of_o(base_of),
        .in_win_o (in_win),
        .widx_o   (wr_widx)
    );

    fbw_stage_buf #(
        .WORDS(BUF_WORDS),
        .WIDTH(BUS_W)
    ) buf_i (
        .clk_i  (clk_i),
        .we_i   (buf_we),
        .waddr_i(buf_widx),
        .wdata_i(buf_wdata),
        .raddr_i(q.idx[IW-1:0]),
        .rdata_o(buf_rdata)
    );

    assign idx_end = (q.idx == IDX_W'(BUF_WORDS));

    always_comb begin
        d           = q;
        d.ra        = 1'b0;
        d.pend      = 1'b0;
        buf_we      = 1'b0;
        buf_widx    = wr_widx;
        buf_wdata   = wr_data_i;
        arr_rd_o    = 1'b0;
        arr_we_o    = 1'b0;
        arr_addr_o  = q.base;
        arr_wdata_o = buf_rdata;
        unique case (q.state)
            ST_IDLE: begin
                if (wr_valid_i && wr_data_i[7:0] == CMD_START) begin
                    d.state = ST_COUNT;
                    d.err   = 1'b0;
                end
            end
            ST_COUNT: begin
                if (wr_valid_i) begin
                    d.cnt   = wr_data_i[CNT_W-1:0];
                    d.base  = base_of;
                    d.win   = 1'b1;
                    d.idx   = '0;
                    d.rdy   = 1'b0;
                    d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                if (!idx_end) begin
                    arr_rd_o   = 1'b1;
                    arr_addr_o = q.base + (ADDR_W'(q.idx[IW-1:0]) << WB);
                    d.pend     = 1'b1;
                    d.pidx     = q.idx[IW-1:0];
                    d.idx      = q.idx + 1'b1;
                end else begin
                    d.state = ST_DATA;
                end
                if (q.pend) begin
                    buf_we    = 1'b1;
                    buf_widx  = q.pidx;
                    buf_wdata = arr_rdata_i;
                end
            end
            ST_DATA: begin
                if (wr_valid_i) begin
                    d.rdy = 1'b1;
                    if (ro_i || !in_win) begin
                        d.err = 1'b1;
                    end else begin
                        buf_we = 1'b1;
                    end
                    if (q.cnt == '0) begin
                        d.state = ST_CONFIRM;
                    end
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CONFIRM: begin
                if (wr_valid_i) begin
                    if (wr_data_i[7:0] == CMD_CONFIRM && !q.err) begin
                        d.state = ST_DRAIN;
                        d.idx   = '0;
                        d.rdy   = 1'b0;
                    end else begin
                        d.state = ST_IDLE;
                        d.win   = 1'b0;
                        d.ra    = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (!idx_end) begin
                    d.pend = 1'b1;
                    d.pidx = q.idx[IW-1:0];
                    d.idx  = q.idx + 1'b1;
                end else begin
                    d.state = ST_IDLE;
                    d.win   = 1'b0;
                    d.rdy   = 1'b1;
                end
                if (q.pend) begin
                    arr_we_o   = 1'b1;
                    arr_addr_o = q.base + (ADDR_W'(q.pidx) << WB);
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.win   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.rdy   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.state == ST_FILL) || (q.state == ST_DRAIN);
    assign ready_o      = q.rdy;
    assign prog_err_o   = q.err;
    assign win_valid_o  = q.win;
    assign read_array_o = q.ra;

    // R10: stray idle writes leave the unit idle
    assert_idle_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IDLE && wr_valid_i && wr_data_i[7:0] != CMD_START)
        |=> (q.state == ST_IDLE && !win_valid_o));

    // R3: the array is only written while a window is open
    assert_we_needs_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_we_o |-> (win_valid_o && !arr_rd_o));

    // R4: an out-of-window data write never reaches the buffer and flags an error
    assert_bounds_error_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_DATA && wr_valid_i && !in_win) |-> (!buf_we ##1 prog_err_o));

    // R8: read-only writes flag an error
    assert_readonly_error_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_DATA && wr_valid_i && ro_i) |=> prog_err_o);

    // R7: a rejected confirm closes the window without touching the array
    assert_abort_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_CONFIRM && wr_valid_i && (wr_data_i[7:0] != CMD_CONFIRM || prog_err_o))
        |=> (!win_valid_o && read_array_o && !busy_o && !arr_we_o));

    // R6: the last copy-out cycle returns to idle with ready set
    assert_commit_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_DRAIN && idx_end) |=> (!win_valid_o && ready_o && !busy_o));

    // R9: ready stays low while a copy runs
    assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !ready_o);

endmodule

// File: tb/flash_bufwrite_stager_tb_top.sv
`timescale 1ns/1ps
module flash_bufwrite_stager_tb_top;
    localparam int ADDR_W    = 13;
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 32;
    localparam int BUF_BYTES = 2048 * 2;
    localparam int BUF_WORDS = BUF_BYTES / BUS_BYTES;
    localparam int ARR_WORDS = (1 << ADDR_W) / BUS_BYTES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ro = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [BUS_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_rd;
    logic [BUS_W-1:0]  arr_rdata;
    logic              arr_we;
    logic [BUS_W-1:0]  arr_wdata;
    logic              busy, ready, perr, winv, rdarr;

    int checks = 0;
    int errors = 0;

    logic [BUS_W-1:0] arr     [ARR_WORDS];
    logic [BUS_W-1:0] exp_arr [ARR_WORDS];

    always #4 clk = ~clk;

    flash_bufwrite_stager dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ro_i(ro),
        .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .arr_addr_o(arr_addr), .arr_rd_o(arr_rd), .arr_rdata_i(arr_rdata),
        .arr_we_o(arr_we), .arr_wdata_o(arr_wdata),
        .busy_o(busy), .ready_o(ready), .prog_err_o(perr),
        .win_valid_o(winv), .read_array_o(rdarr)
    );

    always @(posedge clk) begin
        if (arr_we) arr[arr_addr[ADDR_W-1:2]] <= arr_wdata;
        if (arr_rd) arr_rdata <= arr[arr_addr[ADDR_W-1:2]];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] dat);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cmp_array(input string req);
        int mism = 0;
        for (int i = 0; i < ARR_WORDS; i++) if (arr[i] !== exp_arr[i]) mism++;
        chk(mism == 0, req, mism, 0);
    endtask

    task automatic open_win(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] cnt, input string req);
        int n;
        wr(a, 32'h0000_00E8);
        chk(perr == 1'b0, {req, " err cleared at start (R4)"}, perr, 0);
        wr(a, cnt);
        wait_busy(n);
        chk(n == BUF_WORDS + 1, {req, " fill busy cycles (R9)"}, n, BUF_WORDS + 1);
        chk(winv == 1'b1, {req, " window open"}, winv, 1);
    endtask

    task automatic t_reset();
        chk(busy == 0 && winv == 0, "R1 idle after reset", {busy, winv}, 0);
        chk(ready == 1, "R1 ready after reset", ready, 1);
        chk(perr == 0 && rdarr == 0, "R1 err/pulse after reset", {perr, rdarr}, 0);
    endtask

    task automatic t_idle_ignore();
        wr(13'h0000, 32'h0000_00D0);
        wr(13'h0004, 32'h1234_5678);
        chk(winv == 0 && busy == 0, "R10 no window from stray writes", {winv, busy}, 0);
        cmp_array("R10 array untouched");
    endtask

    task automatic t_commit_masked();
        int n;
        open_win(13'h1123, 32'hABCD_0002, "R2");
        wr(13'h1000, 32'hD1D1_0001);
        chk(ready == 1, "R5 ready after data write", ready, 1);
        wr(13'h1008, 32'hD2D2_0002);
        wr(13'h1FFC, 32'hD3D3_0003);
        chk(winv == 1 && busy == 0, "R5 still waiting for confirm", {winv, busy}, 2);
        wr(13'h1000, 32'h0000_00D0);
        chk(ready == 0, "R9 ready low during copy-out", ready, 0);
        wait_busy(n);
        chk(n == BUF_WORDS + 1, "R9 drain busy cycles", n, BUF_WORDS + 1);
        chk(ready == 1 && winv == 0, "R6 commit closes window", {ready, winv}, 2);
        exp_arr[1024] = 32'hD1D1_0001;
        exp_arr[1026] = 32'hD2D2_0002;
        exp_arr[2047] = 32'hD3D3_0003;
        cmp_array("R6 R3 R2 committed contents");
    endtask

    task automatic t_count_one();
        int n;
        open_win(13'h07F4, 32'h0000_0001, "R5");
        wr(13'h0010, 32'hCAFE_0010);
        wr(13'h0FFC, 32'hCAFE_0FFC);
        wr(13'h0000, 32'h0000_00D0);
        wait_busy(n);
        exp_arr[4]    = 32'hCAFE_0010;
        exp_arr[1023] = 32'hCAFE_0FFC;
        cmp_array("R5 count+1 writes then confirm");
    endtask

    task automatic t_bounds();
        open_win(13'h0040, 32'h0000_0001, "R4a");
        wr(13'h0020, 32'h1111_1111);
        wr(13'h1000, 32'h2222_2222);
        chk(perr == 1, "R4 past-end write flags error", perr, 1);
        wr(13'h0000, 32'h0000_00D0);
        chk(rdarr == 1, "R7 abort pulse on pending error", rdarr, 1);
        chk(winv == 0 && busy == 0, "R7 window closed", {winv, busy}, 0);
        cmp_array("R4 R7 nothing committed");
        open_win(13'h1040, 32'h0000_0000, "R4b");
        wr(13'h0FFC, 32'h3333_3333);
        chk(perr == 1, "R4 below-base write flags error", perr, 1);
        wr(13'h1000, 32'h0000_00D0);
        chk(winv == 0 && busy == 0, "R7 closed after error", {winv, busy}, 0);
        cmp_array("R4 below-base untouched");
    endtask

    task automatic t_bad_confirm();
        open_win(13'h0000, 32'h0000_0000, "R7");
        wr(13'h0040, 32'h4444_4444);
        chk(perr == 0, "R7 clean write no error", perr, 0);
        wr(13'h0000, 32'h0000_00FF);
        chk(rdarr == 1, "R7 read-array pulse", rdarr, 1);
        @(negedge clk);
        chk(rdarr == 0, "R7 pulse one cycle", rdarr, 0);
        cmp_array("R7 discard leaves array");
    endtask

    task automatic t_readonly();
        open_win(13'h1000, 32'h0000_0000, "R8");
        ro = 1'b1;
        wr(13'h1010, 32'h5555_5555);
        chk(perr == 1, "R8 read-only flags error", perr, 1);
        ro = 1'b0;
        wr(13'h1000, 32'h0000_00D0);
        chk(busy == 0 && winv == 0, "R8 no commit", {busy, winv}, 0);
        cmp_array("R8 array unchanged");
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ARR_WORDS; i++) begin
            arr[i]     = 32'h5A00_0000 ^ (i * 32'h0001_0003);
            exp_arr[i] = 32'h5A00_0000 ^ (i * 32'h0001_0003);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_commit_masked();
        t_count_one();
        t_bounds();
        t_bad_confirm();
        t_readonly();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule